// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the raster timing for a display pipe. It runs in the pixel clock domain. Each axis is programmed with four segment lengths: sync pulse, back porch, active region and front porch. The block adds these into four running boundaries per axis, all measured from the first cycle of the sync pulse: back-porch start, active start, front-porch start and total. A horizontal counter walks each line. A vertical counter steps once per line. From the two counters the block decodes the horizontal and vertical sync pulses, a data-enable strobe, the coordinates inside the active window, and a one-cycle vertical-event interrupt on the first line of the vertical front porch.

A run enable turns the generator on and off. When the enable is low, both counters are held at zero and every output sits at its idle level, so dropping the enable blanks the display. While the generator runs, the segment inputs are taken only at frame boundaries. Software may therefore rewrite them at any time, and the frame that is already in flight is never torn.

Top module: `raster_timing_gen`

## Requirements
- R1: Per axis, the boundaries are back-porch start = sync length, active start = back-porch start + back porch, front-porch start = active start + active size, and total = front-porch start + front porch. Every boundary counts from the first sync cycle, which is position 0.
- R2: While running, the horizontal position counts 0 up to total-1 and then returns to 0. The vertical position advances by one only when the horizontal position wraps, and it returns to 0 after line vertical total-1.
- R3: A sync output is asserted while its axis position is below that axis's back-porch start. A polarity input of 1 makes the sync active high, and 0 makes it active low.
- R4: dataEn is 1 only when both positions lie in [active start, front-porch start). During dataEn, xPos and yPos equal the position minus the active start. Otherwise they are 0.
- R5: When the event-enable input is 1, vEventIrq is a one-cycle pulse in the cycle where the vertical position equals the vertical front-porch start and the horizontal position is 0. When the event-enable input is 0, vEventIrq stays 0.
- R6: While syncEn is low, both positions are held at 0, dataEn and vEventIrq are 0, and both syncs sit at their inactive level. After syncEn rises, the first clock edge starts the generator at position (0,0), and the position then advances by one on each later edge.
- R7: While running, changes to the segment inputs take effect only at the wrap from the last position of a frame to (0,0). While stopped, the segment inputs are captured on every clock.
- R8: After reset, the generator is stopped and all outputs are at their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncEn | input | 1 | Run enable; low blanks the display and clears the counters |
| hSyncLen | input | CNT_W | Horizontal sync length in pixels |
| hBackPorch | input | CNT_W | Horizontal back porch in pixels |
| hActive | input | CNT_W | Active width in pixels |
| hFrontPorch | input | CNT_W | Horizontal front porch in pixels |
| vSyncLen | input | CNT_W | Vertical sync length in lines |
| vBackPorch | input | CNT_W | Vertical back porch in lines |
| vActive | input | CNT_W | Active height in lines |
| vFrontPorch | input | CNT_W | Vertical front porch in lines |
| hsPolHigh | input | 1 | 1 = horizontal sync active high |
| vsPolHigh | input | 1 | 1 = vertical sync active high |
| vEventEn | input | 1 | Enables the vertical-event interrupt |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| dataEn | output | 1 | Active-region strobe |
| xPos | output | CNT_W | Column inside the active window |
| yPos | output | CNT_W | Row inside the active window |
| vEventIrq | output | 1 | Vertical-event interrupt pulse |

## Verification
The bench builds the block with CNT_W = 8 and uses tiny rasters, with frames of roughly 25 to 85 pixel clocks. At that size it can compare every output on every cycle across several whole frames. This includes each wrap, each sync edge and each interrupt line. Small rasters also make the boundary cases cheap to reach: a reprogram in the middle of a frame, a stop and restart, inverted polarities, and zero-length porches, where the active window touches a sync region or the interrupt line is never reached.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // axis indices
  localparam int AXES = 2;
  localparam int AX_H = 0;
  localparam int AX_V = 1;
  // segment / boundary indices
  localparam int SEGS  = 4;
  localparam int B_BP  = 0;  // back-porch start (= sync length)
  localparam int B_AS  = 1;  // active start
  localparam int B_FP  = 2;  // front-porch start
  localparam int B_TOT = 3;  // total

  typedef struct packed {
    logic live;   // generator is running
    logic clear;  // force counters to zero
    logic step;   // advance horizontal counter
    logic wrapH;  // horizontal counter wraps this edge
    logic wrapV;  // frame wraps this edge
  } rtg_strobe_t;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 syncEn,
  input  logic [AXES-1:0][SEGS-1:0][CNT_W-1:0] segLen,
  input  logic [CNT_W-1:0]                     hCnt,
  input  logic [CNT_W-1:0]                     vCnt,
  output rtg_strobe_t                          strobes,
  output logic [AXES-1:0][SEGS-1:0][CNT_W-1:0] bnd
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic runQ;
  logic endH, endV, loadShadow;
  logic [AXES-1:0][SEGS-1:0][CNT_W-1:0] bndNext;

  // cumulative boundaries from segment lengths
  always_comb begin
    for (int ax = 0; ax < AXES; ax++) begin
      bndNext[ax][0] = segLen[ax][0];
      for (int s = 1; s < SEGS; s++)
        bndNext[ax][s] = bndNext[ax][s-1] + segLen[ax][s];
    end
  end

  assign endH = (hCnt == bnd[AX_H][B_TOT] - ONE);
  assign endV = (vCnt == bnd[AX_V][B_TOT] - ONE);

  always_comb begin
    strobes.live  = runQ;
    strobes.clear = !syncEn;
    strobes.step  = syncEn && runQ;
    strobes.wrapH = syncEn && runQ && endH;
    strobes.wrapV = syncEn && runQ && endH && endV;
  end

  assign loadShadow = !runQ || strobes.wrapV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      bnd  <= '0;
    end else begin
      runQ <= syncEn;
      if (loadShadow) bnd <= bndNext;
    end
  end

  // R7: shadow boundaries hold while running between frame wraps
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !strobes.wrapV) |=> $stable(bnd));

  // R6: a stopped generator is not live one edge later
  a_r6_stop_live: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> !strobes.live);
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  rtg_strobe_t                          strobes,
  input  logic [AXES-1:0][SEGS-1:0][CNT_W-1:0] bnd,
  input  logic                                 hsPolHigh,
  input  logic                                 vsPolHigh,
  input  logic                                 vEventEn,
  output logic [CNT_W-1:0]                     hCnt,
  output logic [CNT_W-1:0]                     vCnt,
  output logic                                 hsyncOut,
  output logic                                 vsyncOut,
  output logic                                 dataEn,
  output logic [CNT_W-1:0]                     xPos,
  output logic [CNT_W-1:0]                     yPos,
  output logic                                 vEventIrq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [AXES-1:0][CNT_W-1:0] cnt;
  logic [AXES-1:0][CNT_W-1:0] rel;
  logic [AXES-1:0]            inSync;
  logic [AXES-1:0]            inAct;

  // position counters
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      cnt <= '0;
    end else if (strobes.step) begin
      if (strobes.wrapH) begin
        cnt[AX_H] <= '0;
        cnt[AX_V] <= strobes.wrapV ? '0 : cnt[AX_V] + ONE;
      end else begin
        cnt[AX_H] <= cnt[AX_H] + ONE;
      end
    end
  end

  assign hCnt = cnt[AX_H];
  assign vCnt = cnt[AX_V];

  // per-axis region decode
  generate
    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
      assign inSync[ax] = cnt[ax] < bnd[ax][B_BP];
      assign inAct[ax]  = (cnt[ax] >= bnd[ax][B_AS]) && (cnt[ax] < bnd[ax][B_FP]);
      assign rel[ax]    = cnt[ax] - bnd[ax][B_AS];
    end
  endgenerate

  always_comb begin
    hsyncOut  = (strobes.live && inSync[AX_H]) ? hsPolHigh : !hsPolHigh;
    vsyncOut  = (strobes.live && inSync[AX_V]) ? vsPolHigh : !vsPolHigh;
    dataEn    = strobes.live && inAct[AX_H] && inAct[AX_V];
    xPos      = dataEn ? rel[AX_H] : '0;
    yPos      = dataEn ? rel[AX_V] : '0;
    vEventIrq = strobes.live && vEventEn &&
                (cnt[AX_V] == bnd[AX_V][B_FP]) && (cnt[AX_H] == '0);
  end

  // R2: counters stay inside the programmed raster
  a_r2_h_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.live |-> (cnt[AX_H] < bnd[AX_H][B_TOT]));
  a_r2_v_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.live |-> (cnt[AX_V] < bnd[AX_V][B_TOT]));
  // R2: the line counter only moves across a horizontal wrap
  a_r2_v_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[AX_H] != '0) |-> $stable(cnt[AX_V]));
  // R6: stopping clears the position and blanks
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (cnt == '0 && !dataEn && !vEventIrq));
  // R5: the event is a single-cycle pulse
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rstN)
    vEventIrq |=> !vEventIrq);
  // R4: active data never overlaps horizontal sync
  a_r4_de_no_sync: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (hsyncOut == !hsPolHigh));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncEn,
  input  logic [CNT_W-1:0] hSyncLen,
  input  logic [CNT_W-1:0] hBackPorch,
  input  logic [CNT_W-1:0] hActive,
  input  logic [CNT_W-1:0] hFrontPorch,
  input  logic [CNT_W-1:0] vSyncLen,
  input  logic [CNT_W-1:0] vBackPorch,
  input  logic [CNT_W-1:0] vActive,
  input  logic [CNT_W-1:0] vFrontPorch,
  input  logic             hsPolHigh,
  input  logic             vsPolHigh,
  input  logic             vEventEn,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             dataEn,
  output logic [CNT_W-1:0] xPos,
  output logic [CNT_W-1:0] yPos,
  output logic             vEventIrq
);
  logic [AXES-1:0][SEGS-1:0][CNT_W-1:0] segLen;
  logic [AXES-1:0][SEGS-1:0][CNT_W-1:0] bnd;
  logic [CNT_W-1:0] hCnt, vCnt;
  rtg_strobe_t strobes;

  assign segLen[AX_H] = {hFrontPorch, hActive, hBackPorch, hSyncLen};
  assign segLen[AX_V] = {vFrontPorch, vActive, vBackPorch, vSyncLen};

  rtg_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncEn  (syncEn),
    .segLen  (segLen),
    .hCnt    (hCnt),
    .vCnt    (vCnt),
    .strobes (strobes),
    .bnd     (bnd)
  );

  rtg_datapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .bnd       (bnd),
    .hsPolHigh (hsPolHigh),
    .vsPolHigh (vsPolHigh),
    .vEventEn  (vEventEn),
    .hCnt      (hCnt),
    .vCnt      (vCnt),
    .hsyncOut  (hsyncOut),
    .vsyncOut  (vsyncOut),
    .dataEn    (dataEn),
    .xPos      (xPos),
    .yPos      (yPos),
    .vEventIrq (vEventIrq)
  );
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, syncEn, hsPol, vsPol, evEn;
  int cfg [2][4];
  logic hsyncOut, vsyncOut, dataEn, vEventIrq;
  logic [W-1:0] xPos, yPos;

  raster_timing_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .syncEn(syncEn),
    .hSyncLen(W'(cfg[0][0])), .hBackPorch(W'(cfg[0][1])),
    .hActive(W'(cfg[0][2])), .hFrontPorch(W'(cfg[0][3])),
    .vSyncLen(W'(cfg[1][0])), .vBackPorch(W'(cfg[1][1])),
    .vActive(W'(cfg[1][2])), .vFrontPorch(W'(cfg[1][3])),
    .hsPolHigh(hsPol), .vsPolHigh(vsPol), .vEventEn(evEn),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .dataEn(dataEn),
    .xPos(xPos), .yPos(yPos), .vEventIrq(vEventIrq)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  int cur [2][4];
  int mh = 0;
  int mv = 0;
  bit mlive = 0;

  function automatic int bd(int ax, int b);
    int s = 0;
    for (int i = 0; i <= b; i++) s += cur[ax][i];
    return s;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at h=%0d v=%0d: actual=%0d expected=%0d", tag, mh, mv, act, exp);
    end
  endtask

  task automatic checkNow(string sc);
    bit hs, vs, de, irq;
    int ex, ey;
    hs  = (mlive && mh < bd(0, 0)) ? hsPol : !hsPol;
    vs  = (mlive && mv < bd(1, 0)) ? vsPol : !vsPol;
    de  = mlive && mh >= bd(0, 1) && mh < bd(0, 2) && mv >= bd(1, 1) && mv < bd(1, 2);
    ex  = de ? mh - bd(0, 1) : 0;
    ey  = de ? mv - bd(1, 1) : 0;
    irq = mlive && evEn && mv == bd(1, 2) && mh == 0;
    if (!mlive) sc = {sc, " R6 idle"};
    cmp({sc, " R3 hsync"}, int'(hsyncOut), int'(hs));
    cmp({sc, " R3 vsync"}, int'(vsyncOut), int'(vs));
    cmp({sc, " R4 dataEn"}, int'(dataEn), int'(de));
    cmp({sc, " R4 xPos"}, int'(xPos), ex);
    cmp({sc, " R4 yPos"}, int'(yPos), ey);
    cmp({sc, " R5 irq"}, int'(vEventIrq), int'(irq));
  endtask

  // R2 / R7 model: advance once per clock edge
  task automatic stepModel();
    bit wasLive = mlive;
    if (!wasLive) cur = cfg;
    if (!syncEn) begin
      mlive = 0; mh = 0; mv = 0;
    end else if (!wasLive) begin
      mlive = 1; mh = 0; mv = 0;
    end else if (mh == bd(0, 3) - 1) begin
      mh = 0;
      if (mv == bd(1, 3) - 1) begin
        mv = 0;
        cur = cfg;
      end else mv++;
    end else mh++;
  endtask

  task automatic runCycles(int n, string sc);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      stepModel();
      @(negedge clk);
      checkNow(sc);
    end
  endtask

  task automatic setCfg(int h0, int h1, int h2, int h3, int v0, int v1, int v2, int v3);
    cfg[0][0] = h0; cfg[0][1] = h1; cfg[0][2] = h2; cfg[0][3] = h3;
    cfg[1][0] = v0; cfg[1][1] = v1; cfg[1][2] = v2; cfg[1][3] = v3;
  endtask

  initial begin
    rstN = 0; syncEn = 0; hsPol = 1; vsPol = 1; evEn = 1;
    setCfg(3, 2, 5, 2, 2, 1, 3, 1);   // 12 x 7 raster
    cur = cfg;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkNow("R8 reset");
    runCycles(3, "R8 after reset");

    // R1 R2 R3 R4 R5: two full frames, polarity active high
    syncEn = 1;
    runCycles(2 * 84 + 5, "R1 R2 base");

    // R7: reprogram mid-frame, inverted polarity, event masked (R5)
    hsPol = 0; vsPol = 0; evEn = 0;
    setCfg(2, 3, 4, 1, 1, 2, 2, 2);   // 10 x 7 raster
    runCycles(84 + 2 * 70, "R7 reprogram");

    // R6: stop mid-frame, then restart with new timing captured while stopped
    evEn = 1;
    runCycles(17, "R5 event on");
    syncEn = 0;
    runCycles(6, "R6 stopped");
    setCfg(1, 1, 2, 1, 1, 1, 2, 1);   // 5 x 5 raster
    hsPol = 1;
    runCycles(2, "R7 stopped capture");
    syncEn = 1;
    runCycles(60, "R6 restart");

    // R4 R5: zero porches; event line equals total and is never reached
    setCfg(4, 0, 3, 0, 1, 0, 2, 0);   // 7 x 3 raster
    runCycles(25 + 3 * 21, "R4 zero porch");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule